// File: doc/BRIEF.md
# Immediate Barrel Shifter with Carry-Out

This unit shifts or rotates a 32-bit operand by an amount taken from an instruction word and produces the new carry flag that a flag-setting data-processing operation would record. It serves the operand path of a RISC core. The instruction word comes in with a format select. A small decoder extracts the shift type, the 5-bit amount and the source register index from one of three instruction layouts.

An encoded amount of zero has a special meaning for each type:
- For a left shift it is a plain pass-through.
- For a logical or arithmetic right shift it means a shift by 32.
- For a rotate it selects a one-bit rotate through the incoming carry.

The carry-out is taken from a bit position that depends on the type. It is flagged by a carry-valid strobe only when flags are being updated and the operation actually defines a carry. Otherwise the incoming carry is passed through unchanged.

The unit registers all of its outputs once. Results appear one clock after the inputs are presented.

Top module: `shimm_top`

## Requirements
- R1: Shift type code 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. A logical left shift by n in 1..31 gives operand<<n with carry candidate operand bit [32-n].
- R2: A logical left shift with encoded amount 0 returns the operand unchanged, keeps carryValid low and drives carryOut equal to carryIn.
- R3: Logical right by n in 1..31 gives operand>>n with carry candidate bit [n-1]. Encoded amount 0 means 32: the result is zero and the carry candidate is bit 31.
- R4: Arithmetic right by n in 1..31 fills with bit 31, with carry candidate bit [n-1]. Encoded amount 0 means 32: every result bit equals operand bit 31, and so does the carry candidate.
- R5: Rotate right by n in 1..31 gives a rotation of the operand with carry candidate bit [n-1].
- R6: Rotate with encoded amount 0 returns {carryIn, operand[31:1]} with carry candidate operand bit 0.
- R7: carryValid is high exactly when the flag enable is active and the operation is not a left shift by 0. When carryValid is high, carryOut is the carry candidate; otherwise carryOut equals carryIn.
- R8: With fmt=0 (classic), the amount is instr[11:7], the type is instr[6:5], srcReg is instr[3:0], and the flag enable is setFlags.
- R9: With fmt=1 (wide), the amount is {instr[14:12], instr[7:6]}, the type is instr[5:4], srcReg is instr[3:0], and the flag enable is setFlags.
- R10: With fmt=2 (compact 16-bit), the type is instr[12:11], the amount is instr[10:6], and srcReg is {0, instr[5:3]}. The flag enable is the inverse of inCondBlock, and setFlags has no effect.
- R11: With fmt=3, the operand passes through unchanged, carryValid is low, carryOut equals carryIn and srcReg is zero.
- R12: All outputs are registered: they reflect the inputs of the previous clock edge, and reset drives them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| instr | input | 32 | instruction word holding the shift fields |
| fmt | input | 2 | format select: 0 classic, 1 wide, 2 compact, 3 bypass |
| operand | input | 32 | value to shift |
| carryIn | input | 1 | current carry flag |
| setFlags | input | 1 | flag-update request for fmt 0 and 1 |
| inCondBlock | input | 1 | compact format only: high suppresses flag update |
| result | output | 32 | shifted value (registered) |
| carryOut | output | 1 | new carry flag, or carryIn when none is defined |
| carryValid | output | 1 | high when carryOut is a newly defined carry |
| srcReg | output | 4 | decoded source register index |

## Verification
The bench sweeps every type against all 32 encoded amounts, in each decodable format, with both carry-in values. It compares each output with a model that builds shifts from wide concatenations rather than from bit indexing.

Each zero-amount meaning gets its own targeted checks:
- A design that treats right shifts by zero as pass-through returns the operand instead of zero or the sign fill.
- A design that forgets the extended rotate returns the operand or loses the carry in bit 31.
- An off-by-one carry index shows as a wrong carryOut on operands with isolated set bits.

Flag gating is checked with the enable off and carryIn set opposite to the candidate. In the compact format the checks cover setFlags high inside a conditional block, and inCondBlock low with setFlags low. Each of these cases exposes a design that leaks a computed carry or a stray valid strobe.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int REG_W   = 4;

  typedef enum logic [1:0] {
    FMT_CLASSIC = 2'd0,
    FMT_WIDE    = 2'd1,
    FMT_COMPACT = 2'd2,
    FMT_BYPASS  = 2'd3
  } fmt_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic               opLsl;
    logic               opLsr;
    logic               opAsr;
    logic               opRor;
    logic               amtZero;
    logic               flagEn;
    logic [SHAMT_W-1:0] amount;
    logic [REG_W-1:0]   srcReg;
  } shiftCtrl_t;
endpackage

// File: rtl/shimm_ctrl.sv
module shimm_ctrl
  import shimm_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [1:0]  fmt,
  input  logic        setFlags,
  input  logic        inCondBlock,
  output shiftCtrl_t  ctrl
);
  logic [1:0]         kind;
  logic [SHAMT_W-1:0] amt;
  logic [REG_W-1:0]   rm;
  logic               flagReq;

  always_comb begin
    case (fmt_e'(fmt))
      FMT_CLASSIC: begin
        kind    = instr[6:5];
        amt     = instr[11:7];
        rm      = instr[3:0];
        flagReq = setFlags;
      end
      FMT_WIDE: begin
        kind    = instr[5:4];
        amt     = {instr[14:12], instr[7:6]};
        rm      = instr[3:0];
        flagReq = setFlags;
      end
      FMT_COMPACT: begin
        kind    = instr[12:11];
        amt     = instr[10:6];
        rm      = {1'b0, instr[5:3]};
        flagReq = ~inCondBlock;
      end
      default: begin
        kind    = 2'd0;
        amt     = '0;
        rm      = '0;
        flagReq = 1'b0;
      end
    endcase
  end

  always_comb begin
    ctrl.opLsl   = (kind == 2'd0);
    ctrl.opLsr   = (kind == 2'd1);
    ctrl.opAsr   = (kind == 2'd2);
    ctrl.opRor   = (kind == 2'd3);
    ctrl.amtZero = (amt == '0);
    ctrl.flagEn  = flagReq;
    ctrl.amount  = amt;
    ctrl.srcReg  = rm;
  end
endmodule

// File: rtl/shimm_dp.sv
module shimm_dp
  import shimm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtrl_t        ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryValid,
  output logic [REG_W-1:0]  srcReg
);
  localparam int MSB = DATA_W - 1;

  logic [SHAMT_W-1:0]  lslIdx;
  logic [SHAMT_W-1:0]  nm1;
  logic [2*DATA_W-1:0] rotWide;
  logic [DATA_W-1:0]   asrVal;
  logic [DATA_W-1:0]   resNext;
  logic                cyCand;
  logic                validNext;
  logic                primed;

  assign lslIdx  = '0 - ctrl.amount;          // DATA_W - n modulo DATA_W
  assign nm1     = ctrl.amount - 1'b1;
  assign rotWide = {operand, operand} >> ctrl.amount;
  assign asrVal  = $signed(operand) >>> ctrl.amount;

  always_comb begin
    resNext = operand;
    cyCand  = carryIn;
    if (ctrl.opLsl) begin
      if (!ctrl.amtZero) begin
        resNext = operand << ctrl.amount;
        cyCand  = operand[lslIdx];
      end
    end else if (ctrl.opLsr) begin
      if (ctrl.amtZero) begin
        resNext = '0;
        cyCand  = operand[MSB];
      end else begin
        resNext = operand >> ctrl.amount;
        cyCand  = operand[nm1];
      end
    end else if (ctrl.opAsr) begin
      if (ctrl.amtZero) begin
        resNext = {DATA_W{operand[MSB]}};
        cyCand  = operand[MSB];
      end else begin
        resNext = asrVal;
        cyCand  = operand[nm1];
      end
    end else begin
      if (ctrl.amtZero) begin
        resNext = {carryIn, operand[MSB:1]};
        cyCand  = operand[0];
      end else begin
        resNext = rotWide[DATA_W-1:0];
        cyCand  = operand[nm1];
      end
    end
  end

  assign validNext = ctrl.flagEn & ~(ctrl.opLsl & ctrl.amtZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      carryOut   <= 1'b0;
      carryValid <= 1'b0;
      srcReg     <= '0;
      primed     <= 1'b0;
    end else begin
      result     <= resNext;
      carryOut   <= validNext ? cyCand : carryIn;
      carryValid <= validNext;
      srcReg     <= ctrl.srcReg;
      primed     <= 1'b1;
    end
  end

  p_type_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({ctrl.opLsl, ctrl.opLsr, ctrl.opAsr, ctrl.opRor}));

  p_lsl_zero_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(ctrl.opLsl && ctrl.amtZero)
      |-> (result == $past(operand)) && !carryValid);

  p_lsr_zero_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(ctrl.opLsr && ctrl.amtZero) |-> result == '0);

  p_asr_zero_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(ctrl.opAsr && ctrl.amtZero)
      |-> ($countones(result) == 0 || $countones(result) == DATA_W)
          && result[0] == $past(operand[MSB]));

  p_rrx_top_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(ctrl.opRor && ctrl.amtZero) |-> result[MSB] == $past(carryIn));

  p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    primed && !carryValid |-> carryOut == $past(carryIn));
endmodule

// File: rtl/shimm_top.sv
module shimm_top
  import shimm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instr,
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              setFlags,
  input  logic              inCondBlock,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryValid,
  output logic [REG_W-1:0]  srcReg
);
  shiftCtrl_t ctrl;

  shimm_ctrl u_ctrl (
    .instr       (instr),
    .fmt         (fmt),
    .setFlags    (setFlags),
    .inCondBlock (inCondBlock),
    .ctrl        (ctrl)
  );

  shimm_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .operand    (operand),
    .carryIn    (carryIn),
    .result     (result),
    .carryOut   (carryOut),
    .carryValid (carryValid),
    .srcReg     (srcReg)
  );
endmodule

// File: tb/test_shimm_top.sv
`timescale 1ns/1ps
module test_shimm_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  fmt = '0;
  logic [31:0] operand = '0;
  logic        carryIn = 1'b0;
  logic        setFlags = 1'b0;
  logic        inCondBlock = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryValid;
  logic [3:0]  srcReg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] res;
    logic        cy;
    logic        v;
    logic [3:0]  src;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  shimm_top i_shimm_top (
    .clk(clk), .rstN(rstN), .instr(instr), .fmt(fmt), .operand(operand),
    .carryIn(carryIn), .setFlags(setFlags), .inCondBlock(inCondBlock),
    .result(result), .carryOut(carryOut), .carryValid(carryValid), .srcReg(srcReg)
  );

  // Reference built from wide concatenations
  task automatic model(input int k, input int n, input logic [31:0] op,
                       input logic cin, input logic fe,
                       output logic [31:0] res, output logic cy, output logic v);
    logic [63:0] x;
    int sh;
    res = op;
    cy  = cin;
    sh  = (n == 0) ? 32 : n;
    case (k)
      0: if (n != 0) begin
           x = {32'h0, op} << n;
           res = x[31:0];
           cy = x[32];
         end
      1: begin
           x = {op, 32'h0} >> sh;
           res = x[63:32];
           cy = x[31];
         end
      2: begin
           x = $signed({op, 32'h0}) >>> sh;
           res = x[63:32];
           cy = x[31];
         end
      default: if (n == 0) begin
           res = {cin, op[31:1]};
           cy = op[0];
         end else begin
           x = {op, op} >> n;
           res = x[31:0];
           cy = res[31];
         end
    endcase
    v = fe && !(k == 0 && n == 0);
    if (!v) cy = cin;
  endtask

  function automatic string kindTag(int k, int n);
    if (k == 0) return (n == 0) ? "R2" : "R1";
    if (k == 1) return "R3";
    if (k == 2) return "R4";
    return (n == 0) ? "R6" : "R5";
  endfunction

  task automatic drive(input int f, input int k, input int n, input logic [31:0] op,
                       input logic cin, input logic sf, input logic icb,
                       input logic [3:0] rm, input string extra);
    logic [31:0] w;
    exp_t e;
    logic fe;
    w = $urandom;
    fe = 1'b0;
    e.src = 4'h0;
    case (f)
      0: begin
           w[11:7] = 5'(n); w[6:5] = 2'(k); w[3:0] = rm;
           fe = sf; e.src = rm;
           e.tag = {kindTag(k, n), "/R8"};
         end
      1: begin
           w[14:12] = 3'(n >> 2); w[7:6] = 2'(n); w[5:4] = 2'(k); w[3:0] = rm;
           fe = sf; e.src = rm;
           e.tag = {kindTag(k, n), "/R9"};
         end
      2: begin
           w[12:11] = 2'(k); w[10:6] = 5'(n); w[5:3] = rm[2:0];
           fe = !icb; e.src = {1'b0, rm[2:0]};
           e.tag = {kindTag(k, n), "/R10"};
         end
      default: e.tag = "R11";
    endcase
    if (f == 3) begin
      e.res = op; e.cy = cin; e.v = 1'b0;
    end else begin
      model(k, n, op, cin, fe, e.res, e.cy, e.v);
    end
    if (!fe && f != 3) e.tag = {e.tag, "/R7"};
    if (extra != "") e.tag = {e.tag, "/", extra};
    @(negedge clk);
    instr = w; fmt = 2'(f); operand = op; carryIn = cin;
    setFlags = sf; inCondBlock = icb;
    q.push_back(e);
  endtask

  // monitor / scoreboard (R12: one-cycle latency)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (result !== e.res || carryOut !== e.cy || carryValid !== e.v || srcReg !== e.src) begin
          bad++;
          $display("FAIL %s/R12: got res=%h cy=%b v=%b src=%h exp res=%h cy=%b v=%b src=%h",
                   e.tag, result, carryOut, carryValid, srcReg, e.res, e.cy, e.v, e.src);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state, with busy inputs
    operand = 32'hFFFF_FFFF; carryIn = 1'b1; setFlags = 1'b1; instr = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (result !== 32'h0 || carryOut !== 1'b0 || carryValid !== 1'b0 || srcReg !== 4'h0) begin
      bad++;
      $display("FAIL R12 reset: got res=%h cy=%b v=%b src=%h exp all zero",
               result, carryOut, carryValid, srcReg);
    end
    @(negedge clk);
    rstN = 1'b1;

    // corner operands: isolated bits expose off-by-one carry indexes (R1 R3 R4 R5)
    for (int n = 0; n < 32; n++) begin
      for (int k = 0; k < 4; k++) begin
        drive(0, k, n, 32'h8000_0001, 1'b0, 1'b1, 1'b0, 4'd5, "edgeA");
        drive(0, k, n, 32'h7FFF_FFFE, 1'b1, 1'b1, 1'b0, 4'd9, "edgeB");
      end
    end

    // full sweep: formats, types, amounts, carry-in values
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 4; k++) begin
        for (int n = 0; n < 32; n++) begin
          for (int c = 0; c < 2; c++) begin
            drive(f, k, n, $urandom, c[0], 1'($urandom), 1'($urandom), 4'($urandom), "");
          end
        end
      end
    end

    // R7: flags off, carryIn opposite of candidate
    drive(0, 1, 1, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd1, "noflag");
    drive(1, 3, 0, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd2, "noflag");
    drive(0, 2, 0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd3, "noflag");

    // R10: setFlags ignored in compact format
    drive(2, 1, 0, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 4'd7, "cond_blk");
    drive(2, 1, 0, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'd6, "outside_blk");
    drive(2, 0, 0, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 4'd4, "lsl0");

    // R11: bypass format
    drive(3, 0, 0, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 4'd0, "");
    drive(3, 0, 0, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'd0, "");
    drive(3, 0, 0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 4'd0, "");

    // R6: extended rotate with both carry values
    drive(0, 3, 0, 32'h0000_0003, 1'b1, 1'b1, 1'b0, 4'd8, "rrx1");
    drive(0, 3, 0, 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b0, 4'd8, "rrx0");

    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule